// File: doc/BRIEF.md
# Digital Loop Filter for an Oscillator Control Word

This block steers a digitally controlled oscillator toward a nominal frequency. It holds a 12-bit control word. The upper 4 bits select the oscillator's divider and the lower 8 bits select its stage setting. A frequency comparator reports one of six error bands together with a one-cycle update strobe. On each strobe the word moves by a signed step whose size follows the band: a coarse step when the error is large, a medium step in the middle bands and a fine step near nominal.

The word is treated as one binary number, so a carry or borrow out of the stage field changes the divider field. The arithmetic wraps modulo 4096 and never saturates. The oscillator accepts divider codes only up to 9, so any divider code from 10 to 15 is presented as 9, which is the slowest setting. A word that has drifted into that range returns through ordinary subtract steps. A registered lock flag reports when the last reported band lies within ±5 percent of nominal.

Top module: `dlf_ctrl`

## Requirements
- R1: A synchronous reset, active high, loads the word 0x480 and clears the lock flag. The word is visible on `word_o` one clock after reset is sampled.
- R2: In a cycle with `upd_i` low, the word and the lock flag keep their values whatever `band_i` carries.
- R3: When `upd_i` is high, band code 0 (below 0.85 of nominal) subtracts 32, code 1 (0.85 to 0.95) subtracts 8 and code 2 (0.95 up to nominal) subtracts 1. The new word appears on the next clock edge.
- R4: When `upd_i` is high, band code 3 (nominal up to 1.05) adds 1, code 4 (1.05 to 1.15) adds 8 and code 5 (1.15 or above) adds 32.
- R5: Band codes 6 and 7 carried with a strobe leave the word unchanged and clear the lock flag.
- R6: The arithmetic on the word is modulo 4096. For example, 0x000 − 1 gives 0xFFF, 0xFFF + 1 gives 0x000 and 0x000 − 32 gives 0xFE0.
- R7: The divider field (bits 11:8) and the stage field (bits 7:0) are updated as one number. For example, 0x0FF + 1 gives 0x100, 0x100 − 1 gives 0x0FF and 0x9FF + 1 gives 0xA00.
- R8: `div_o` equals word bits 11:8 when they are 9 or less, and equals 9 when they are 10 to 15. `stage_o` always equals word bits 7:0.
- R9: A strobe with band code 2 or 3 sets the lock flag. A strobe with any other code clears it on the same edge that updates the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | One-cycle update strobe from the comparator |
| band_i | input | 3 | Error band code (0 to 5 are used, 6 and 7 are unused) |
| div_o | output | 4 | Divider code for the oscillator, limited to 9 |
| stage_o | output | 8 | Stage setting for the oscillator |
| word_o | output | 12 | Raw 12-bit control word |
| lock_o | output | 1 | Lock flag, error within ±5 percent |

## Verification
The bench goes after the places where the word crosses a boundary:
- Wrap from 0x000 down to 0xFFF and back. A saturating design would stick at 0x000 or at 0xFFF.
- Carry and borrow across bit 8 at 0x0FF and 0x100. A design that keeps the fields separate would wrap the stage field and leave the divider field unchanged.
- The step from 0x9FF up to 0xA00, and words in the 0xAxx to 0xFxx range. A missing limit would show as `div_o` values above 9.

The lock flag is driven through sets followed by unused codes and by outer bands. This exposes a flag that is sticky, or that ignores the strobe. Random band sequences with idle gaps then compare every output against a reference model in the bench.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    localparam int BAND_W = 3;

    typedef enum logic [BAND_W-1:0] {
        BAND_SLOW_FAR  = 3'd0,
        BAND_SLOW_MID  = 3'd1,
        BAND_SLOW_NEAR = 3'd2,
        BAND_FAST_NEAR = 3'd3,
        BAND_FAST_MID  = 3'd4,
        BAND_FAST_FAR  = 3'd5
    } band_e;

    typedef enum logic [1:0] {
        SZ_NONE   = 2'd0,
        SZ_FINE   = 2'd1,
        SZ_MEDIUM = 2'd2,
        SZ_COARSE = 2'd3
    } step_size_e;

    typedef struct packed {
        logic       valid;
        logic       sub;
        step_size_e size;
        logic       lock;
    } step_req_t;

endpackage

// File: rtl/dlf_band_decode.sv
module dlf_band_decode
    import dlf_pkg::*;
#(
    parameter int W           = 12,
    parameter int STEP_FINE   = 1,
    parameter int STEP_MEDIUM = 8,
    parameter int STEP_COARSE = 32
) (
    input  logic [BAND_W-1:0] band_i,
    output logic [W-1:0]      mag_o,
    output logic              sub_o,
    output logic              valid_o,
    output logic              lock_o
);

    step_req_t req;

    always_comb begin
        req = '{valid: 1'b0, sub: 1'b0, size: SZ_NONE, lock: 1'b0};
        case (band_i)
            BAND_SLOW_FAR:  req = '{valid: 1'b1, sub: 1'b1, size: SZ_COARSE, lock: 1'b0};
            BAND_SLOW_MID:  req = '{valid: 1'b1, sub: 1'b1, size: SZ_MEDIUM, lock: 1'b0};
            BAND_SLOW_NEAR: req = '{valid: 1'b1, sub: 1'b1, size: SZ_FINE,   lock: 1'b1};
            BAND_FAST_NEAR: req = '{valid: 1'b1, sub: 1'b0, size: SZ_FINE,   lock: 1'b1};
            BAND_FAST_MID:  req = '{valid: 1'b1, sub: 1'b0, size: SZ_MEDIUM, lock: 1'b0};
            BAND_FAST_FAR:  req = '{valid: 1'b1, sub: 1'b0, size: SZ_COARSE, lock: 1'b0};
            default:        req = '{valid: 1'b0, sub: 1'b0, size: SZ_NONE,   lock: 1'b0};
        endcase
    end

    always_comb begin
        case (req.size)
            SZ_FINE:   mag_o = W'(STEP_FINE);
            SZ_MEDIUM: mag_o = W'(STEP_MEDIUM);
            SZ_COARSE: mag_o = W'(STEP_COARSE);
            default:   mag_o = '0;
        endcase
        sub_o   = req.sub;
        valid_o = req.valid;
        lock_o  = req.lock;
    end

endmodule

// File: rtl/dlf_word_reg.sv
module dlf_word_reg #(
    parameter int          W          = 12,
    parameter logic [W-1:0] RESET_WORD = 12'h480
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd_i,
    input  logic         valid_i,
    input  logic         sub_i,
    input  logic [W-1:0] mag_i,
    input  logic         lock_i,
    output logic [W-1:0] word_o,
    output logic         lock_o
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         lock;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (upd_i) begin
            if (valid_i) begin
                if (sub_i) state_d.word = state_q.word - mag_i;
                else       state_d.word = state_q.word + mag_i;
            end
            state_d.lock = valid_i & lock_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.word <= RESET_WORD;
            state_q.lock <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o = state_q.word;
    assign lock_o = state_q.lock;

    // R1
    reset_load_chk: assert property (@(posedge clk) rst |=> (word_o == RESET_WORD) && !lock_o);

endmodule

// File: rtl/dlf_div_limit.sv
module dlf_div_limit #(
    parameter int DIV_W   = 4,
    parameter int DIV_MAX = 9
) (
    input  logic [DIV_W-1:0] raw_i,
    output logic [DIV_W-1:0] lim_o
);

    localparam int FULL = (1 << DIV_W) - 1;

    generate
        if (DIV_MAX >= FULL) begin : g_pass
            assign lim_o = raw_i;
        end else begin : g_clamp
            localparam logic [DIV_W-1:0] CAP = DIV_W'(DIV_MAX);
            always_comb begin
                if (raw_i > CAP) lim_o = CAP;
                else             lim_o = raw_i;
            end
        end
    endgenerate

endmodule

// File: rtl/dlf_ctrl.sv
module dlf_ctrl
    import dlf_pkg::*;
#(
    parameter int DIV_W       = 4,
    parameter int STG_W       = 8,
    parameter int DIV_MAX     = 9,
    parameter int STEP_FINE   = 1,
    parameter int STEP_MEDIUM = 8,
    parameter int STEP_COARSE = 32,
    parameter logic [DIV_W+STG_W-1:0] RESET_WORD = 12'h480
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd_i,
    input  logic [BAND_W-1:0]      band_i,
    output logic [DIV_W-1:0]       div_o,
    output logic [STG_W-1:0]       stage_o,
    output logic [DIV_W+STG_W-1:0] word_o,
    output logic                   lock_o
);

    localparam int W = DIV_W + STG_W;

    logic [W-1:0] step_mag;
    logic         step_sub;
    logic         step_vld;
    logic         step_lock;

    dlf_band_decode #(
        .W          (W),
        .STEP_FINE  (STEP_FINE),
        .STEP_MEDIUM(STEP_MEDIUM),
        .STEP_COARSE(STEP_COARSE)
    ) u_decode (
        .band_i (band_i),
        .mag_o  (step_mag),
        .sub_o  (step_sub),
        .valid_o(step_vld),
        .lock_o (step_lock)
    );

    dlf_word_reg #(
        .W         (W),
        .RESET_WORD(RESET_WORD)
    ) u_word (
        .clk    (clk),
        .rst    (rst),
        .upd_i  (upd_i),
        .valid_i(step_vld),
        .sub_i  (step_sub),
        .mag_i  (step_mag),
        .lock_i (step_lock),
        .word_o (word_o),
        .lock_o (lock_o)
    );

    dlf_div_limit #(
        .DIV_W  (DIV_W),
        .DIV_MAX(DIV_MAX)
    ) u_limit (
        .raw_i(word_o[W-1:STG_W]),
        .lim_o(div_o)
    );

    assign stage_o = word_o[STG_W-1:0];

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(word_o) && $stable(lock_o));

    // R3
    coarse_down_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && band_i == 3'd0) |=> word_o == W'($past(word_o) - W'(STEP_COARSE)));

    // R4
    coarse_up_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && band_i == 3'd5) |=> word_o == W'($past(word_o) + W'(STEP_COARSE)));

    // R5
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && band_i > 3'd5) |=> $stable(word_o) && !lock_o);

    // R9
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && band_i != 3'd2 && band_i != 3'd3) |=> !lock_o);

    // R8
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(div_o) <= DIV_MAX);

endmodule

// File: tb/dlf_ctrl_tb.sv
`timescale 1ns/1ps
module dlf_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_i = 1'b0;
    logic [2:0]  band_i = 3'd0;
    logic [3:0]  div_o;
    logic [7:0]  stage_o;
    logic [11:0] word_o;
    logic        lock_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int m_word;
    bit m_lock;

    always #5 clk = ~clk;

    dlf_ctrl u_dut (
        .clk(clk), .rst(rst), .upd_i(upd_i), .band_i(band_i),
        .div_o(div_o), .stage_o(stage_o), .word_o(word_o), .lock_o(lock_o)
    );

    function automatic int step_of(input int b);
        case (b)
            0: return -32;
            1: return -8;
            2: return -1;
            3: return 1;
            4: return 8;
            5: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic int div_of(input int w);
        int d = (w >> 8) & 15;
        return (d > 9) ? 9 : d;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string wreq);
        chk(int'(word_o) == m_word, wreq, int'(word_o), m_word);
        chk(int'(div_o) == div_of(m_word), "R8 div", int'(div_o), div_of(m_word));
        chk(int'(stage_o) == (m_word & 255), "R8 stage", int'(stage_o), m_word & 255);
        chk(lock_o == m_lock, "R9 lock", int'(lock_o), int'(m_lock));
    endtask

    task automatic apply(input int b, input string wreq);
        @(negedge clk);
        upd_i = 1'b1;
        band_i = 3'(b);
        @(negedge clk);
        upd_i = 1'b0;
        m_word = (m_word + step_of(b)) & 12'hFFF;
        m_lock = (b == 2) || (b == 3);
        check_all(wreq);
    endtask

    task automatic idle(input int b);
        @(negedge clk);
        upd_i = 1'b0;
        band_i = 3'(b);
        @(negedge clk);
        check_all("R2 hold");
    endtask

    task automatic goto_word(input int target);
        while (m_word != target) begin
            int diff = (target - m_word) & 12'hFFF;
            if (diff >= 32)     apply(5, "R4 walk");
            else if (diff >= 8) apply(4, "R4 walk");
            else                apply(3, "R4 walk");
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_word = 12'h480;
        m_lock = 1'b0;
        check_all("R1 reset");

        for (int i = 0; i < 8; i++) idle(i);

        for (int b = 0; b < 6; b++) begin
            m_word = m_word;
            apply(b, (b < 3) ? "R3 step" : "R4 step");
        end

        goto_word(12'h0FF);
        apply(3, "R7 carry 0x0FF+1");
        apply(2, "R7 borrow 0x100-1");

        goto_word(12'h000);
        apply(2, "R6 wrap 0x000-1");
        apply(3, "R6 wrap 0xFFF+1");
        apply(0, "R6 wrap 0x000-32");

        goto_word(12'h9FF);
        apply(3, "R7 carry 0x9FF+1");
        apply(5, "R8 clamped region");

        apply(2, "R9 set");
        apply(6, "R5 code 6");
        apply(3, "R9 set");
        apply(7, "R5 code 7");
        apply(3, "R9 set");
        apply(4, "R9 clear by band 4");
        apply(2, "R9 set");
        apply(0, "R9 clear by band 0");

        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 10);
            if (r < 2) begin
                idle(int'($urandom % 8));
            end else begin
                int b = int'($urandom % 8);
                apply(b, (b < 3) ? "R3 random" : (b < 6) ? "R4 random" : "R5 random");
            end
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_word = 12'h480;
        m_lock = 1'b0;
        check_all("R1 second reset");

        done = 1'b1;
        finish_run();
    end

endmodule